// File: doc/BRIEF.md
# Segmented Cache Victim Pointer Controller

This block holds the replacement state of a segmented set-associative cache for test access. Each segment has a victim pointer, a lockdown base and an advance mode. A test access (CAM read, CAM write, RAM read or RAM write) to a segment uses that segment's victim pointer as its line index. The access may then step the pointer forward, so a whole segment can be walked one line at a time.

Two load commands place a 32-bit command word into a segment. One loads the victim pointer and the lockdown base together. The other loads the victim pointer only. The command last used on a segment sets whether RAM accesses advance that segment's pointer. When a pointer steps past the last line it returns to the segment's lockdown base, so locked lines below the base are never offered as victims. Every CAM read also copies the addressed segment's pointer into a debug register, so software can restore the pointer afterwards.

Top module: `victim_ptr_ctrl`

## Requirements
- R1: While `acc_seg` selects a segment, `line_idx` shows that segment's current victim pointer in the same cycle. No register sits on this path.
- R2: In a load command word, the line index comes from bits 31:26 and the segment number from bits 7:5. All other bits have no effect.
- R3: A load with `ld_base`=1 sets the segment's victim pointer and its lockdown base to the index. It also puts the segment in all-access mode.
- R4: A load with `ld_base`=0 sets only the victim pointer and leaves the lockdown base unchanged. It puts the segment in CAM-only mode.
- R5: In all-access mode, every access to the segment advances its pointer at the next clock edge, whatever `acc_type` is.
- R6: In CAM-only mode, CAM reads (`acc_type`=00) and CAM writes (01) advance the pointer. RAM reads (10) and RAM writes (11) leave it unchanged.
- R7: An advance from line 63 loads the segment's lockdown base instead of incrementing.
- R8: A CAM read stores the addressed segment's pointer, as it was before any advance, into `dbg_victim` at the next edge. Other access types and loads leave `dbg_victim` unchanged.
- R9: A load or an access changes only the segment it addresses.
- R10: If a load and an access hit the same segment in the same cycle, the load sets the pointer. The access still gets the old index, and a CAM read still captures the old value.
- R11: After reset, every victim pointer, every lockdown base and `dbg_victim` are 0, and every segment is in CAM-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load command strobe |
| ld_base | input | 1 | 1: load the pointer and the lockdown base; 0: load the pointer only |
| ld_word | input | 32 | Load command word (index in 31:26, segment in 7:5) |
| acc_valid | input | 1 | Test access strobe |
| acc_type | input | 2 | 00 CAM read, 01 CAM write, 10 RAM read, 11 RAM write |
| acc_seg | input | 3 | Segment addressed by the access |
| line_idx | output | 6 | Line index for the access: the selected segment's pointer |
| dbg_victim | output | 6 | Pointer captured by the last CAM read |

## Verification
The assertions assume that each strobe lasts one cycle and that `acc_seg` can change between any two cycles. They check only the cycle that follows a load or a CAM access, and only when the next access names the same segment, so they make no assumption about how accesses are ordered. The bench drives every input on the falling edge and holds strobes for exactly one clock. It sweeps all segments, both load commands and the index values around the wrap boundary. It puts non-zero values in the don't-care bits of the command word, and it also applies a load and an access in the same cycle.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    typedef enum logic [1:0] {
        ACC_CAM_RD = 2'b00,
        ACC_CAM_WR = 2'b01,
        ACC_RAM_RD = 2'b10,
        ACC_RAM_WR = 2'b11
    } acc_e;

    function automatic logic is_cam(input logic [1:0] t);
        return ~t[1];
    endfunction
endpackage

// File: rtl/vpc_cmd_decode.sv
module vpc_cmd_decode #(
    parameter int CMD_W   = 32,
    parameter int IDX_W   = 6,
    parameter int SEG_W   = 3,
    parameter int SEG_LSB = 5
) (
    input  logic                     ld_valid,
    input  logic [CMD_W-1:0]         ld_word,
    input  logic                     acc_valid,
    input  logic [SEG_W-1:0]         acc_seg,
    output logic [IDX_W-1:0]         ld_idx,
    output logic [(1<<SEG_W)-1:0]    ld_sel,
    output logic [(1<<SEG_W)-1:0]    acc_sel
);
    localparam int NUM_SEG = 1 << SEG_W;
    localparam logic [CMD_W-1:0] FIELD_MASK =
        ({CMD_W{1'b1}} << (CMD_W - IDX_W)) |
        (CMD_W'((1 << SEG_W) - 1) << SEG_LSB);

    logic [SEG_W-1:0] ld_seg;
    logic [CMD_W-1:0] unused_sbz;

    assign ld_idx     = ld_word[CMD_W-1 -: IDX_W];
    assign ld_seg     = ld_word[SEG_LSB +: SEG_W];
    assign unused_sbz = ld_word & ~FIELD_MASK;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_sel
        assign ld_sel[s]  = ld_valid  && (ld_seg  == SEG_W'(s));
        assign acc_sel[s] = acc_valid && (acc_seg == SEG_W'(s));
    end
endmodule

// File: rtl/vpc_seg_slot.sv
module vpc_seg_slot #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_hit,
    input  logic             ld_both,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic             acc_hit,
    input  logic             acc_cam,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    typedef struct packed {
        logic [IDX_W-1:0] victim;
        logic [IDX_W-1:0] base;
        logic             all_mode;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_hit) begin
            st_d.victim   = ld_idx;
            st_d.all_mode = ld_both;
            if (ld_both) begin
                st_d.base = ld_idx;
            end
        end else if (acc_hit && (acc_cam || st_q.all_mode)) begin
            if (st_q.victim == LAST) begin
                st_d.victim = st_q.base;
            end else begin
                st_d.victim = st_q.victim + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign victim = st_q.victim;
endmodule

// File: rtl/victim_ptr_ctrl.sv
module victim_ptr_ctrl #(
    parameter int CMD_W   = 32,
    parameter int IDX_W   = 6,
    parameter int SEG_W   = 3,
    parameter int SEG_LSB = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic             ld_base,
    input  logic [CMD_W-1:0] ld_word,
    input  logic             acc_valid,
    input  logic [1:0]       acc_type,
    input  logic [SEG_W-1:0] acc_seg,
    output logic [IDX_W-1:0] line_idx,
    output logic [IDX_W-1:0] dbg_victim
);
    import vpc_pkg::*;

    localparam int NUM_SEG = 1 << SEG_W;

    logic [IDX_W-1:0]              ld_idx;
    logic [NUM_SEG-1:0]            ld_sel;
    logic [NUM_SEG-1:0]            acc_sel;
    logic [NUM_SEG-1:0][IDX_W-1:0] vic_all;
    logic                          acc_cam;

    typedef struct packed {
        logic [IDX_W-1:0] dbg;
    } top_t;

    top_t r_d, r_q;

    assign acc_cam = is_cam(acc_type);

    vpc_cmd_decode #(
        .CMD_W  (CMD_W),
        .IDX_W  (IDX_W),
        .SEG_W  (SEG_W),
        .SEG_LSB(SEG_LSB)
    ) u_dec (
        .ld_valid (ld_valid),
        .ld_word  (ld_word),
        .acc_valid(acc_valid),
        .acc_seg  (acc_seg),
        .ld_idx   (ld_idx),
        .ld_sel   (ld_sel),
        .acc_sel  (acc_sel)
    );

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_slot
        vpc_seg_slot #(.IDX_W(IDX_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_hit (ld_sel[s]),
            .ld_both(ld_base),
            .ld_idx (ld_idx),
            .acc_hit(acc_sel[s]),
            .acc_cam(acc_cam),
            .victim (vic_all[s])
        );
    end

    assign line_idx = vic_all[acc_seg];

    always_comb begin
        r_d = r_q;
        if (acc_valid && (acc_type == ACC_CAM_RD)) begin
            r_d.dbg = vic_all[acc_seg];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dbg_victim = r_q.dbg;
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
    parameter int CMD_W   = 32,
    parameter int IDX_W   = 6,
    parameter int SEG_W   = 3,
    parameter int SEG_LSB = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic [CMD_W-1:0] ld_word,
    input logic             acc_valid,
    input logic [1:0]       acc_type,
    input logic [SEG_W-1:0] acc_seg,
    input logic [IDX_W-1:0] line_idx,
    input logic [IDX_W-1:0] dbg_victim
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (!(acc_valid && acc_seg == $past(ld_word[SEG_LSB +: SEG_W]))
                      || line_idx == $past(ld_word[CMD_W-1 -: IDX_W]))); // R2

    AST_DBG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_type == 2'b00) |=> dbg_victim == $past(line_idx)); // R8

    AST_DBG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_type == 2'b00) |=> $stable(dbg_victim)); // R8

    AST_CAM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_type[1] && !ld_valid && line_idx != LAST)
        |=> (!(acc_valid && acc_seg == $past(acc_seg))
             || line_idx == IDX_W'($past(line_idx) + IDX_W'(1)))); // R6
endmodule

bind victim_ptr_ctrl vpc_checker #(
    .CMD_W  (CMD_W),
    .IDX_W  (IDX_W),
    .SEG_W  (SEG_W),
    .SEG_LSB(SEG_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_word   (ld_word),
    .acc_valid (acc_valid),
    .acc_type  (acc_type),
    .acc_seg   (acc_seg),
    .line_idx  (line_idx),
    .dbg_victim(dbg_victim)
);

// File: tb/victim_ptr_ctrl_test.sv
`timescale 1ns/1ps
module victim_ptr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_base = 1'b0;
    logic [31:0] ld_word = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_type = '0;
    logic [2:0]  acc_seg = '0;
    logic [5:0]  line_idx;
    logic [5:0]  dbg_victim;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [5:0] m_vic [8];
    logic [5:0] m_base [8];
    bit         m_all [8];
    logic [5:0] m_dbg;

    always #2.5 clk = ~clk;

    victim_ptr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_base(ld_base),
        .ld_word(ld_word), .acc_valid(acc_valid), .acc_type(acc_type),
        .acc_seg(acc_seg), .line_idx(line_idx), .dbg_victim(dbg_victim)
    );

    task automatic chk(input logic [5:0] act, input logic [5:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] step(input int s);
        return (m_vic[s] == 6'd63) ? m_base[s] : m_vic[s] + 6'd1;
    endfunction

    // R2: junk in the don't-care bits must have no effect
    task automatic do_load(input bit both, input int s, input logic [5:0] idx, input logic [31:0] junk);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_base  = both;
        ld_word  = {idx, junk[25:8], 3'(s), junk[4:0]};
        @(posedge clk);
        m_vic[s] = idx;
        m_all[s] = both;
        if (both) m_base[s] = idx;
        #1 ld_valid = 1'b0;
        chk(dbg_victim, m_dbg, "R8 load keeps debug");
    endtask

    task automatic do_acc(input logic [1:0] t, input int s);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_type  = t;
        acc_seg   = 3'(s);
        #1 chk(line_idx, m_vic[s], "R1 index of segment");
        @(posedge clk);
        if (t == 2'b00) m_dbg = m_vic[s];
        if (!t[1] || m_all[s]) m_vic[s] = step(s); // R5 R6 R7
        #1 acc_valid = 1'b0;
        chk(dbg_victim, m_dbg, "R8 debug capture");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_vic[i] = '0; m_base[i] = '0; m_all[i] = 1'b0;
        end
        m_dbg = '0;
        repeat (3) @(posedge clk);
        #1 chk(dbg_victim, 6'd0, "R11 debug reset");
        rst_n = 1'b1;
        // R11: all pointers zero and CAM-only mode (RAM read does not advance)
        for (int s = 0; s < 8; s++) begin
            do_acc(2'b10, s);
            do_acc(2'b10, s);
        end
        // Sweep: R3 R4 R5 R6 R7 R9
        for (int s = 0; s < 8; s++) begin
            for (int both = 0; both < 2; both++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [5:0] idx;
                    idx = (k == 0) ? 6'd0 : (k == 1) ? 6'd5 : (k == 2) ? 6'd60 : 6'd63;
                    do_load(both[0], s, idx, 32'hA5C3_5F1B ^ 32'(s * 977 + k));
                    for (int n = 0; n < 72; n++) begin
                        do_acc(2'(n % 4), s);
                        if (n % 9 == 0) do_acc(2'(n % 4), (s + 3) % 8); // R9
                    end
                end
            end
        end
        // R4: victim-only load keeps the base; wrap goes to the old base
        do_load(1'b1, 2, 6'd20, 32'h0);
        do_load(1'b0, 2, 6'd62, 32'hFFFF_FFFF);
        do_acc(2'b01, 2);
        do_acc(2'b01, 2);
        chk(m_vic[2], 6'd20, "R7 model sanity");
        do_acc(2'b00, 2);
        // R10: load and CAM read on the same segment in the same cycle
        do_load(1'b0, 4, 6'd10, 32'h0);
        @(negedge clk);
        ld_valid = 1'b1; ld_base = 1'b0; ld_word = {6'd40, 18'd0, 3'd4, 5'd0};
        acc_valid = 1'b1; acc_type = 2'b00; acc_seg = 3'd4;
        #1 chk(line_idx, 6'd10, "R10 old index");
        @(posedge clk);
        #1 ld_valid = 1'b0; acc_valid = 1'b0;
        m_dbg = 6'd10; m_vic[4] = 6'd40; m_all[4] = 1'b0;
        chk(dbg_victim, 6'd10, "R10 debug old value");
        do_acc(2'b10, 4);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule